// File: doc/BRIEF.md
# Battery-Backed Clock and Scratch Memory Serial Slave

This block is a bit-serial slave that holds a free-running 32-bit seconds counter, a sixteen-word battery-backed scratch memory, a snapshot word, a pair of power timers, two control words and four test words. All of them sit in a 24-bit address space. A host selects the block, shifts in a 32-bit command word and then moves one 32-bit data word: it shifts the word in for a write, or shifts it out for a read. A 1 Hz tick input stands in for the crystal oscillator. Two sticky flags in control word 0 report unstable power and a low battery.

Both bit streams use valid/ready handshakes. A bit moves only in a cycle where valid and ready are both high. The host may drop in_valid or out_ready for any number of cycles. While out_valid is high and out_ready is low, the slave holds out_bit steady. in_ready and out_valid can only be high while sel is high. Dropping sel abandons the current transfer, and the next selection starts a new command. Each transfer is started afresh by raising sel.

The memory word at 0x200004 is where the host keeps its time offset. To the block it is an ordinary memory word, and it does no arithmetic with it.

Top module: `rtc_sram_slave`

## Requirements
- R1: The command word is 32 bits, sent most significant bit first. Bit 31 set selects a write. Bits 30:8 carry address bits 22:0, with address bit 23 taken as 0. Bits 7:0 are ignored.
- R2: On a write, the next 32 input bits, most significant first, are stored at the addressed register in the cycle after the last bit is accepted.
- R3: On a read, out_valid rises after the command. The value is captured once, in the cycle after the last command bit is accepted, and 32 bits are then sent most significant bit first. A tick during the shift does not alter the word being sent.
- R4: Bits move only when valid and ready are both high. out_bit stays steady while out_ready is low. in_ready and out_valid are low whenever sel is low, and both are never high together. Dropping sel abandons the transfer, and no write happens.
- R5: The seconds counter (0x200000) adds one in each cycle where tick_1hz is high, and it wraps from 0xFFFFFFFF to 0.
- R6: A host write to the counter loads the raw value, and counting resumes from it. A write in the same cycle as a tick takes priority.
- R7: These words are readable and writable: memory words 0x200001 to 0x200010 (which include the offset word 0x200004), the snapshot 0x204000, the on timer 0x210000, the off timer 0x210001 and control word 1 at 0x21000D.
- R8: Test words 0x210004 to 0x210007 read as 0 and ignore writes. Control word 0 (0x21000C) has no storage of its own.
- R9: A read of an unmapped address returns 0. A write to an unmapped address changes nothing.
- R10: Control word 0 bit 11 (unstable power) is set by reset and by pwr_fail. It stays set until a write to 0x21000C has bit 11 at 1. If a set and a clear arrive together, the set wins.
- R11: Control word 0 bit 9 (low battery) is set while batt_low is high. It stays set until a write to 0x21000C has bit 9 at 1. All other bits of control word 0 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| pwr_fail | input | 1 | Power-glitch indication, sets the unstable flag |
| batt_low | input | 1 | Battery below threshold, sets the low-battery flag |
| sel | input | 1 | Frames one transfer; low aborts and returns to command |
| in_valid | input | 1 | Host offers an input bit |
| in_ready | output | 1 | Slave accepts an input bit |
| in_bit | input | 1 | Serial input bit |
| out_valid | output | 1 | Slave offers an output bit |
| out_ready | input | 1 | Host takes the output bit |
| out_bit | output | 1 | Serial output bit |

## Verification
The assertions check on every cycle the rules that never change. in_ready and out_valid drop with sel and are never high together. out_bit holds while the host stalls. The counter steps by exactly one on a tick, or takes the written value when a write lands. The unstable flag falls only on a write with bit 11 set. Only the bench scenarios can show the end-to-end behaviour: that each address decodes to the right storage, that read-only and unmapped writes leave nothing behind, and that a tick during a read leaves the captured word alone. They also show that an abort in the data phase discards the write, and that reset restores the flags and clears the memory.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [23:0] A_COUNT   = 24'h200000;
  localparam logic [23:0] A_MEM0    = 24'h200001;
  localparam logic [23:0] A_SNAP    = 24'h204000;
  localparam logic [23:0] A_TON     = 24'h210000;
  localparam logic [23:0] A_TOFF    = 24'h210001;
  localparam logic [23:0] A_CTL0    = 24'h21000C;
  localparam logic [23:0] A_CTL1    = 24'h21000D;
  localparam int          UNSTABLE_BIT = 11;
  localparam int          LOWBAT_BIT   = 9;

  typedef enum logic [2:0] {
    L_CMD, L_WDAT, L_LATCH, L_RDAT, L_HOLD
  } link_state_e;
endpackage

// File: rtl/rtc_link.sv
module rtc_link
  import rtc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_bit,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] rd_data
);
  localparam int CW    = $clog2(DATA_W);
  localparam int SHIFT = DATA_W - ADDR_W;
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  link_state_e      st_q;
  logic [CW-1:0]    cnt_q;
  logic [DATA_W-1:0] in_sh_q, out_sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic             wr_q;

  assign in_ready  = sel && (st_q == L_CMD || st_q == L_WDAT);
  assign out_valid = sel && (st_q == L_RDAT);
  assign out_bit   = out_sh_q[DATA_W-1];
  assign acc_addr  = addr_q;
  assign wr_en     = wr_q;
  assign wr_data   = in_sh_q;

  wire in_go  = in_valid && in_ready;
  wire out_go = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= L_CMD; cnt_q <= '0; in_sh_q <= '0; out_sh_q <= '0;
      addr_q <= '0; wr_q <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (!sel) begin
        st_q  <= L_CMD;
        cnt_q <= '0;
      end else begin
        unique case (st_q)
          L_CMD, L_WDAT: if (in_go) begin
            in_sh_q <= {in_sh_q[DATA_W-2:0], in_bit};
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
              cnt_q <= '0;
              if (st_q == L_CMD) begin
                // flag bit replaces the address MSB; low bits are ignored
                addr_q <= {1'b0, in_sh_q[DATA_W-3:SHIFT-1]};
                st_q   <= in_sh_q[DATA_W-2] ? L_WDAT : L_LATCH;
              end else begin
                wr_q <= 1'b1;
                st_q <= L_HOLD;
              end
            end
          end
          L_LATCH: begin
            out_sh_q <= rd_data;
            st_q     <= L_RDAT;
          end
          L_RDAT: if (out_go) begin
            out_sh_q <= {out_sh_q[DATA_W-2:0], 1'b0};
            cnt_q    <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
              cnt_q <= '0;
              st_q  <= L_HOLD;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 24,
  parameter int SRAM_WORDS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              pwr_fail,
  input  logic              batt_low,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] count,
  output logic              unstable
);
  localparam int IW = (SRAM_WORDS > 1) ? $clog2(SRAM_WORDS) : 1;

  logic [DATA_W-1:0] count_q, snap_q, ton_q, toff_q, ctl1_q;
  logic [DATA_W-1:0] mem_q [SRAM_WORDS];
  logic              unstable_q, lowbat_q;

  wire [ADDR_W-1:0] mem_off = acc_addr - ADDR_W'(A_MEM0);
  wire              mem_hit = (acc_addr >= ADDR_W'(A_MEM0)) &&
                              (mem_off < ADDR_W'(SRAM_WORDS));
  wire [IW-1:0]     mem_idx = mem_off[IW-1:0];

  wire hit_cnt  = acc_addr == ADDR_W'(A_COUNT);
  wire hit_ctl0 = acc_addr == ADDR_W'(A_CTL0);
  wire clr_unst = wr_en && hit_ctl0 && wr_data[UNSTABLE_BIT];
  wire clr_lowb = wr_en && hit_ctl0 && wr_data[LOWBAT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0; snap_q <= '0; ton_q <= '0; toff_q <= '0; ctl1_q <= '0;
      unstable_q <= 1'b1; lowbat_q <= 1'b0;
    end else begin
      if (wr_en && hit_cnt)     count_q <= wr_data;
      else if (tick)            count_q <= count_q + 1'b1;
      if (wr_en && acc_addr == ADDR_W'(A_SNAP)) snap_q <= wr_data;
      if (wr_en && acc_addr == ADDR_W'(A_TON))  ton_q  <= wr_data;
      if (wr_en && acc_addr == ADDR_W'(A_TOFF)) toff_q <= wr_data;
      if (wr_en && acc_addr == ADDR_W'(A_CTL1)) ctl1_q <= wr_data;
      if (pwr_fail)      unstable_q <= 1'b1;
      else if (clr_unst) unstable_q <= 1'b0;
      if (batt_low)      lowbat_q <= 1'b1;
      else if (clr_lowb) lowbat_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < SRAM_WORDS; g++) begin : g_mem
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= '0;
      else if (wr_en && mem_hit && mem_idx == IW'(g)) mem_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    if (mem_hit) rd_data = mem_q[mem_idx];
    else begin
      unique case (acc_addr)
        ADDR_W'(A_COUNT): rd_data = count_q;
        ADDR_W'(A_SNAP):  rd_data = snap_q;
        ADDR_W'(A_TON):   rd_data = ton_q;
        ADDR_W'(A_TOFF):  rd_data = toff_q;
        ADDR_W'(A_CTL1):  rd_data = ctl1_q;
        ADDR_W'(A_CTL0): begin
          rd_data[UNSTABLE_BIT] = unstable_q;
          rd_data[LOWBAT_BIT]   = lowbat_q;
        end
        default: rd_data = '0;  // test words and unmapped space
      endcase
    end
  end

  assign count    = count_q;
  assign unstable = unstable_q;
endmodule

// File: rtl/rtc_sram_slave.sv
module rtc_sram_slave #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 24,
  parameter int SRAM_WORDS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1hz,
  input  logic pwr_fail,
  input  logic batt_low,
  input  logic sel,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit
);
  logic [ADDR_W-1:0] acc_addr;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data, rd_data, count_q;
  logic              unstable_q;

  rtc_link #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_link (
    .clk, .rst_n, .sel, .in_valid, .in_ready, .in_bit,
    .out_valid, .out_ready, .out_bit,
    .acc_addr, .wr_en, .wr_data, .rd_data
  );

  rtc_regbank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRAM_WORDS(SRAM_WORDS)) u_regs (
    .clk, .rst_n, .tick(tick_1hz), .pwr_fail, .batt_low,
    .acc_addr, .wr_en, .wr_data, .rd_data,
    .count(count_q), .unstable(unstable_q)
  );
endmodule

// File: rtl/rtc_sram_slave_chk.sv
module rtc_sram_slave_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_bit,
  input logic              tick,
  input logic              wr_en,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] count,
  input logic              unstable
);
  localparam logic [ADDR_W-1:0] CNT_A  = ADDR_W'(24'h200000);
  localparam logic [ADDR_W-1:0] CTL0_A = ADDR_W'(24'h21000C);

  p_gated_by_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (!in_ready && !out_valid));

  p_one_direction_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  p_hold_when_stalled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (!sel || (out_valid && $stable(out_bit))));

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(wr_en && acc_addr == CNT_A)) |=> count == $past(count) + 1'b1);

  p_count_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && acc_addr == CNT_A) |=> count == $past(wr_data));

  p_unstable_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(unstable) |-> $past(wr_en && acc_addr == CTL0_A && wr_data[11]));
endmodule

bind rtc_sram_slave rtc_sram_slave_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk, .rst_n, .sel, .in_ready, .out_valid, .out_ready, .out_bit,
  .tick(tick_1hz), .wr_en, .acc_addr, .wr_data,
  .count(count_q), .unstable(unstable_q)
);

// File: tb/rtc_sram_slave_tb_top.sv
module rtc_sram_slave_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1hz = 0, pwr_fail = 0, batt_low = 0;
  logic sel = 0, in_valid = 0, in_bit = 0, out_ready = 0;
  logic in_ready, out_valid, out_bit;
  int   n_chk = 0, n_fail = 0;
  int   stall_err = 0;
  bit   done = 0;

  always #2 clk = ~clk;  // 250 MHz

  rtc_sram_slave dut_i (
    .clk, .rst_n, .tick_1hz, .pwr_fail, .batt_low,
    .sel, .in_valid, .in_ready, .in_bit, .out_valid, .out_ready, .out_bit
  );

  // row: write flag | address | ignored low byte | write data or expected read
  localparam int NV = 21;
  localparam logic [64:0] VECS [NV] = '{
    {1'b1, 24'h200001, 8'h00, 32'h1111_1111},
    {1'b1, 24'h200004, 8'hA5, 32'hB1A5_0004},
    {1'b1, 24'h200010, 8'h00, 32'hCAFE_0010},
    {1'b1, 24'h204000, 8'h00, 32'h5A5A_5A5A},
    {1'b1, 24'h210000, 8'h00, 32'h0000_0123},
    {1'b1, 24'h210001, 8'h3C, 32'h0000_0456},
    {1'b1, 24'h21000D, 8'h00, 32'h0000_00FF},
    {1'b1, 24'h210005, 8'h00, 32'hFFFF_FFFF},
    {1'b1, 24'h200011, 8'h00, 32'h1234_5678},
    {1'b1, 24'h300000, 8'h00, 32'h8765_4321},
    {1'b0, 24'h200001, 8'hFF, 32'h1111_1111},
    {1'b0, 24'h200004, 8'h00, 32'hB1A5_0004},
    {1'b0, 24'h200010, 8'h00, 32'hCAFE_0010},
    {1'b0, 24'h204000, 8'h00, 32'h5A5A_5A5A},
    {1'b0, 24'h210000, 8'h00, 32'h0000_0123},
    {1'b0, 24'h210001, 8'h00, 32'h0000_0456},
    {1'b0, 24'h21000D, 8'h00, 32'h0000_00FF},
    {1'b0, 24'h210005, 8'h00, 32'h0000_0000},
    {1'b0, 24'h200011, 8'h00, 32'h0000_0000},
    {1'b0, 24'h300000, 8'h00, 32'h0000_0000},
    {1'b0, 24'h200002, 8'h00, 32'h0000_0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push_bit(input logic b);
    @(negedge clk); in_valid = 1'b1; in_bit = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1 in_valid = 1'b0;
  endtask

  task automatic pull_bit(input int stall, output logic b);
    logic v0;
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    v0 = out_bit;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      if (out_bit !== v0 || !out_valid) stall_err++;
    end
    out_ready = 1'b1; b = out_bit;
    @(posedge clk); #1 out_ready = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
  endtask

  // tick_bit >= 0 pulses one tick before that read bit is taken
  task automatic xfer(input logic we, input logic [23:0] a, input logic [7:0] junk,
                      input logic [31:0] wd, input int stall, input int tick_bit,
                      output logic [31:0] rd);
    logic [31:0] cmd;
    logic b;
    cmd = {we, a[22:0], junk};
    rd = '0;
    @(negedge clk); sel = 1'b1;
    for (int i = 31; i >= 0; i--) push_bit(cmd[i]);
    if (we) begin
      for (int i = 31; i >= 0; i--) push_bit(wd[i]);
      @(posedge clk); #1;
    end else begin
      for (int i = 31; i >= 0; i--) begin
        if (i == tick_bit) pulse_tick();
        pull_bit(stall, b);
        rd[i] = b;
      end
    end
    @(negedge clk); sel = 1'b0;
  endtask

  function automatic logic [31:0] rd_of(input logic [23:0] a);
    return 32'h0;
  endfunction

  task automatic wr(input logic [23:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    xfer(1'b1, a, 8'h00, d, 0, -1, dummy);
  endtask

  task automatic rd(input logic [23:0] a, output logic [31:0] d);
    xfer(1'b0, a, 8'h00, 32'h0, 0, -1, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R4 in_ready low while deselected", {31'b0, in_ready}, 32'h0);
    check("R4 out_valid low while deselected", {31'b0, out_valid}, 32'h0);
    rd(24'h21000C, v); check("R10 unstable set by reset", v, 32'h0000_0800);
    rd(24'h200000, v); check("R5 counter zero after reset", v, 32'h0);

    // table: R1 R2 R7 R8 R9
    for (int k = 0; k < NV; k++) begin
      if (VECS[k][64]) begin
        xfer(1'b1, VECS[k][63:40], VECS[k][39:32], VECS[k][31:0], 0, -1, v);
      end else begin
        xfer(1'b0, VECS[k][63:40], VECS[k][39:32], 32'h0, 0, -1, v);
        check($sformatf("R7/R8/R9/R1 table row %0d", k), v, VECS[k][31:0]);
      end
    end

    // R8 control word 0 ignores storage bits
    wr(24'h21000C, 32'h0000_0000);
    rd(24'h21000C, v); check("R8 ctl0 zero write keeps flag", v, 32'h0000_0800);

    // R6 load and R5 wrap, R3 capture vs tick
    wr(24'h200000, 32'hFFFF_FFFE);
    pulse_tick();
    xfer(1'b0, 24'h200000, 8'h00, 32'h0, 0, 20, v);
    check("R3 tick during shift leaves word", v, 32'hFFFF_FFFF);
    rd(24'h200000, v); check("R5 wrap to zero", v, 32'h0);
    pulse_tick(); pulse_tick();
    rd(24'h200000, v); check("R5 two ticks", v, 32'h2);

    // R6 write wins over simultaneous tick
    @(negedge clk); tick_1hz = 1'b1;
    wr(24'h200000, 32'h0000_0100);
    tick_1hz = 1'b0;
    rd(24'h200000, v); check("R6 write beats tick", v, 32'h0000_0100);

    // R4 back-pressure
    stall_err = 0;
    xfer(1'b0, 24'h200004, 8'h00, 32'h0, 3, -1, v);
    check("R4 stalled read data", v, 32'hB1A5_0004);
    check("R4 out_bit steady during stall", stall_err, 0);

    // R4 abort mid-command then normal read
    @(negedge clk); sel = 1'b1;
    for (int i = 0; i < 10; i++) push_bit(1'b1);
    @(negedge clk); sel = 1'b0;
    rd(24'h200010, v); check("R4 abort in command", v, 32'hCAFE_0010);

    // R4 abort mid-write data: no write
    @(negedge clk); sel = 1'b1;
    begin
      logic [31:0] c;
      c = {1'b1, 23'h200005, 8'h00};
      for (int i = 31; i >= 0; i--) push_bit(c[i]);
      for (int i = 0; i < 16; i++) push_bit(1'b1);
    end
    @(negedge clk); sel = 1'b0;
    rd(24'h200005, v); check("R4 aborted write discarded", v, 32'h0);

    // R10 / R11 flags
    wr(24'h21000C, 32'h0000_0800);
    rd(24'h21000C, v); check("R10 unstable cleared", v, 32'h0);
    @(negedge clk); batt_low = 1'b1; @(negedge clk); batt_low = 1'b0;
    rd(24'h21000C, v); check("R11 low battery sticky", v, 32'h0000_0200);
    @(negedge clk); pwr_fail = 1'b1; @(negedge clk); pwr_fail = 1'b0;
    rd(24'h21000C, v); check("R10 pwr_fail sets flag", v, 32'h0000_0A00);
    wr(24'h21000C, 32'h0000_0200);
    rd(24'h21000C, v); check("R11 clear only bit 9", v, 32'h0000_0800);
    wr(24'h21000C, 32'hFFFF_FFFF);
    rd(24'h21000C, v); check("R11 other bits read zero", v, 32'h0);

    // second reset: memory cleared, unstable set
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    rd(24'h200001, v); check("R7 memory cleared by reset", v, 32'h0);
    rd(24'h21000C, v); check("R10 unstable after reset", v, 32'h0000_0800);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule